// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This combinational unit decides where instruction fetch goes next. From the current program counter, the 32-bit instruction word and the two source register values, it works out the following fetch address. It also raises a redirect flag when the instruction changes the flow of control. For a call it additionally supplies a return address and a write request for the fixed link register. The unit handles absolute region jumps, call, register-indirect jump, two-register equality branches and four sign-test branches. Any other word, and any branch whose condition fails, falls through to the next sequential word.

Decoding happens in three stages. A classifier sorts the word into one flow kind, and this is the state that matters inside the block. A condition evaluator and a target generator work in parallel. A final selector picks the address for the decoded kind. The flow kinds are SEQ (fall through), JUMP, CALL, JREG (register jump), EQ, NE, LTZ, GEZ, LEZ and GTZ. Each "transition" is the choice between the kind's target and the sequential address. Only the six conditional kinds depend on register values. JUMP, CALL and JREG always redirect, and SEQ never does.

The return address assumes one delay-slot word after the call. The unit itself still steers fetch straight to the target.

Top module: `next_pc_unit`

## Requirements
- R1: An instruction outside the control-flow set gives pc_next = pc_cur + 4, redirect = 0 and link_we = 0. This includes opcode 0x00 with a function code (bits 5:0) other than 0x08.
- R2: Opcode 0x02 (bits 31:26) gives pc_next = {(pc_cur+4)[31:28], instr[25:0], 2'b00} and redirect = 1.
- R3: Opcode 0x03 gives the same target as R2 with redirect = 1, link_we = 1, link_dst = 31 and link_val = pc_cur + 8.
- R4: Opcode 0x00 with function code 0x08 gives pc_next = rs_val and redirect = 1.
- R5: Opcode 0x04 when rs_val == rt_val, and opcode 0x05 when rs_val != rt_val, give pc_next = pc_cur + 4 + (sign-extended instr[15:0] << 2) and redirect = 1. For example, offset 3 adds 12 to pc_cur + 4.
- R6: A branch whose condition fails gives pc_next = pc_cur + 4 and redirect = 0.
- R7: Opcode 0x01 decodes bits 20:16. Value 0 branches when rs_val is negative (signed), and value 1 branches when rs_val >= 0; the target is as in R5, so offset 2 adds 8. Any other value there is treated as in R1.
- R8: Opcode 0x06 branches when rs_val <= 0 and opcode 0x07 when rs_val > 0, with rs_val taken as signed. This holds only if bits 20:16 are zero; otherwise the word is treated as in R1.
- R9: The jump region comes from pc_cur + 4. A jump held at 0x2FFFFFFC lands in the 0x3xxxxxxx region.
- R10: link_we is 1 only for opcode 0x03. link_dst is 31 when link_we is 1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the register named in bits 25:21 |
| rt_val | input | 32 | Value of the register named in bits 20:16 |
| pc_next | output | 32 | Next fetch address |
| redirect | output | 1 | High when fetch leaves the sequential path |
| link_we | output | 1 | Request to write the return address |
| link_dst | output | 5 | Destination register index for the return address |
| link_val | output | 32 | Return address, pc_cur + 8 |

## Verification
The only internal state is the decoded flow kind, which is recomputed on every input change. A wrong kind shows up in the same evaluation as a wrong pc_next, a redirect flag out of step with the condition, or a spurious link request. A misread sub-field, such as bits 20:16 for the sign-test branches, only appears with particular register signs and field values. Random words are therefore biased toward those opcodes, equal register pairs, zero and negative values. Directed cases cover region crossing and the rejected sub-field encodings.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [3:0] {
        FLOW_SEQ,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_JREG,
        FLOW_EQ,
        FLOW_NE,
        FLOW_LTZ,
        FLOW_GEZ,
        FLOW_LEZ,
        FLOW_GTZ
    } flow_kind_t;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_REGIMM  = 6'h01;
    localparam logic [5:0] OPC_JUMP    = 6'h02;
    localparam logic [5:0] OPC_CALL    = 6'h03;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_BNE     = 6'h05;
    localparam logic [5:0] OPC_BLEZ    = 6'h06;
    localparam logic [5:0] OPC_BGTZ    = 6'h07;
    localparam logic [5:0] FN_JREG     = 6'h08;
    localparam logic [4:0] SUB_LTZ     = 5'd0;
    localparam logic [4:0] SUB_GEZ     = 5'd1;

endpackage

// File: rtl/flow_classifier.sv
module flow_classifier
    import nextpc_pkg::*;
(
    input  logic [31:0] instr,
    output flow_kind_t  kind
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic [4:0] sub;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];
    assign sub = instr[20:16];

    always_comb begin
        kind = FLOW_SEQ;
        unique case (opc)
            OPC_SPECIAL: kind = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            OPC_REGIMM: begin
                if (sub == SUB_LTZ)      kind = FLOW_LTZ;
                else if (sub == SUB_GEZ) kind = FLOW_GEZ;
                else                     kind = FLOW_SEQ;
            end
            OPC_JUMP:   kind = FLOW_JUMP;
            OPC_CALL:   kind = FLOW_CALL;
            OPC_BEQ:    kind = FLOW_EQ;
            OPC_BNE:    kind = FLOW_NE;
            OPC_BLEZ:   kind = (sub == 5'd0) ? FLOW_LEZ : FLOW_SEQ;
            OPC_BGTZ:   kind = (sub == 5'd0) ? FLOW_GTZ : FLOW_SEQ;
            default:    kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/branch_condition.sv
module branch_condition
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_kind_t       kind,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic             take
);
    logic same;
    logic neg;
    logic zero;

    assign same = (rs_val == rt_val);
    assign neg  = rs_val[XLEN-1];
    assign zero = (rs_val == '0);

    always_comb begin
        take = 1'b0;
        unique case (kind)
            FLOW_JUMP, FLOW_CALL, FLOW_JREG: take = 1'b1;
            FLOW_EQ:  take = same;
            FLOW_NE:  take = !same;
            FLOW_LTZ: take = neg;
            FLOW_GEZ: take = !neg;
            FLOW_LEZ: take = neg || zero;
            FLOW_GTZ: take = !neg && !zero;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/target_builder.sv
module target_builder #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] seq_addr,
    output logic [XLEN-1:0] ret_addr,
    output logic [XLEN-1:0] branch_addr,
    output logic [XLEN-1:0] region_addr
);
    localparam int OFS_W    = 16;
    localparam int IDX_W    = 26;
    localparam int LOW_W    = IDX_W + 2;
    localparam int REGION_W = XLEN - LOW_W;
    localparam int EXT_W    = XLEN - OFS_W - 2;

    logic [XLEN-1:0] disp;

    assign seq_addr    = pc_cur + XLEN'(4);
    assign ret_addr    = pc_cur + XLEN'(8);
    assign disp        = {{EXT_W{instr[OFS_W-1]}}, instr[OFS_W-1:0], 2'b00};
    assign branch_addr = seq_addr + disp;
    assign region_addr = {seq_addr[XLEN-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import nextpc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic [XLEN-1:0]   pc_next,
    output logic              redirect,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_dst,
    output logic [XLEN-1:0]   link_val
);
    flow_kind_t      kind;
    logic            take;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] ret_addr;
    logic [XLEN-1:0] branch_addr;
    logic [XLEN-1:0] region_addr;

    flow_classifier u_class (
        .instr (instr),
        .kind  (kind)
    );

    branch_condition #(.XLEN(XLEN)) u_cond (
        .kind   (kind),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .take   (take)
    );

    target_builder #(.XLEN(XLEN)) u_tgt (
        .pc_cur      (pc_cur),
        .instr       (instr),
        .seq_addr    (seq_addr),
        .ret_addr    (ret_addr),
        .branch_addr (branch_addr),
        .region_addr (region_addr)
    );

    always_comb begin
        pc_next = seq_addr;
        unique case (kind)
            FLOW_JUMP, FLOW_CALL: pc_next = region_addr;
            FLOW_JREG:            pc_next = rs_val;
            FLOW_EQ, FLOW_NE, FLOW_LTZ, FLOW_GEZ, FLOW_LEZ, FLOW_GTZ:
                                  pc_next = take ? branch_addr : seq_addr;
            default:              pc_next = seq_addr;
        endcase
    end

    assign redirect = take;
    assign link_we  = (kind == FLOW_CALL);
    assign link_dst = link_we ? RIDX_W'(LINK_REG) : '0;
    assign link_val = ret_addr;
endmodule

// File: rtl/next_pc_checker.sv
module next_pc_checker #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic [XLEN-1:0]   pc_cur,
    input logic [31:0]       instr,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   rt_val,
    input logic [XLEN-1:0]   pc_next,
    input logic              redirect,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_dst,
    input logic [XLEN-1:0]   link_val
);
    logic known;
    assign known = !$isunknown({pc_cur, instr, rs_val, rt_val});

    always_comb begin
        if (known) begin
            p_fallthrough_r6: assert (redirect || pc_next == pc_cur + XLEN'(4))
                else $error("fall-through address wrong");
            p_link_r3: assert (!link_we || (link_val == pc_cur + XLEN'(8) && link_dst == RIDX_W'(31)))
                else $error("link fields wrong");
            p_link_redirect_r10: assert (!link_we || redirect)
                else $error("link without redirect");
            p_jreg_r4: assert (!(instr[31:26] == 6'h00 && instr[5:0] == 6'h08)
                               || (redirect && pc_next == rs_val))
                else $error("register jump wrong");
            p_region_r2: assert (!(instr[31:26] == 6'h02 || instr[31:26] == 6'h03)
                                 || (pc_next[1:0] == 2'b00 && redirect))
                else $error("region jump wrong");
            p_eq_r5: assert (instr[31:26] != 6'h04 || redirect == (rs_val == rt_val))
                else $error("equality branch decision wrong");
        end
    end
endmodule

bind next_pc_unit next_pc_checker #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_next_pc_checker (
    .pc_cur   (pc_cur),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc_next  (pc_next),
    .redirect (redirect),
    .link_we  (link_we),
    .link_dst (link_dst),
    .link_val (link_val)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_cur = '0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc_next;
    logic        redirect;
    logic        link_we;
    logic [4:0]  link_dst;
    logic [31:0] link_val;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    next_pc_unit i_next_pc_unit (
        .pc_cur(pc_cur), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .pc_next(pc_next), .redirect(redirect), .link_we(link_we),
        .link_dst(link_dst), .link_val(link_val)
    );

    task automatic model(input logic [31:0] pc, input logic [31:0] iw,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] nx, output logic tk,
                         output logic we, output logic [4:0] dst, output string tag);
        logic [31:0] p4, br, jt;
        logic cond;
        p4 = pc + 32'd4;
        br = p4 + {{14{iw[15]}}, iw[15:0], 2'b00};
        jt = {p4[31:28], iw[25:0], 2'b00};
        nx = p4; tk = 0; we = 0; dst = 0; tag = "R1"; cond = 0;
        case (iw[31:26])
            6'h00: if (iw[5:0] == 6'h08) begin nx = a; tk = 1; tag = "R4"; end
            6'h02: begin nx = jt; tk = 1; tag = "R2"; end
            6'h03: begin nx = jt; tk = 1; we = 1; dst = 5'd31; tag = "R3"; end
            6'h04: begin cond = (a == b); tag = cond ? "R5" : "R6"; end
            6'h05: begin cond = (a != b); tag = cond ? "R5" : "R6"; end
            6'h01: begin
                if (iw[20:16] == 5'd0)      begin cond = $signed(a) < 0;  tag = "R7"; end
                else if (iw[20:16] == 5'd1) begin cond = $signed(a) >= 0; tag = "R7"; end
                else tag = "R7";
            end
            6'h06: begin tag = "R8"; if (iw[20:16] == 0) cond = $signed(a) <= 0; end
            6'h07: begin tag = "R8"; if (iw[20:16] == 0) cond = $signed(a) > 0; end
            default: ;
        endcase
        if (cond) begin nx = br; tk = 1; end
    endtask

    task automatic apply_check(input logic [31:0] pc, input logic [31:0] iw,
                               input logic [31:0] a, input logic [31:0] b, input string note);
        logic [31:0] enx; logic etk, ewe; logic [4:0] edst; string tag;
        @(negedge clk);
        pc_cur = pc; instr = iw; rs_val = a; rt_val = b;
        #1;
        model(pc, iw, a, b, enx, etk, ewe, edst, tag);
        total++;
        if (pc_next !== enx || redirect !== etk || link_we !== ewe || link_dst !== edst
            || (ewe && link_val !== pc + 32'd8)) begin
            bad++;
            $display("FAIL %s %s: got next=%h tk=%b we=%b dst=%0d lv=%h exp next=%h tk=%b we=%b dst=%0d lv=%h",
                     tag, note, pc_next, redirect, link_we, link_dst, link_val,
                     enx, etk, ewe, edst, pc + 32'd8);
        end
    endtask

    function automatic logic [31:0] rand_word(input logic [5:0] op);
        logic [31:0] w;
        w = $urandom;
        w[31:26] = op;
        if (($urandom % 2) == 0) w[20:16] = 5'($urandom % 3);
        if (op == 6'h00 && ($urandom % 2) == 0) w[5:0] = 6'h08;
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 initial state: all-zero word is a plain shift, falls through
        apply_check(32'h0000_0000, 32'h0000_0000, 0, 0, "reset-state fall-through R1");
        apply_check(32'h0040_0010, 32'h2005_0005, 7, 7, "add-immediate R1");
        apply_check(32'h0040_0010, 32'h0000_0009, 7, 7, "special non-jr func R1");
        // R2 / R9 region behaviour
        apply_check(32'h1000_0000, 32'h0900_0000, 0, 0, "jump R2");
        apply_check(32'h2FFF_FFFC, 32'h0800_0010, 0, 0, "region crossing R9");
        // R3 / R10 call
        apply_check(32'h0040_0020, 32'h0D00_0040, 0, 0, "call link R3 R10");
        // R4 register jump
        apply_check(32'h0040_0000, 32'h0060_0008, 32'hABCD_1234, 0, "register jump R4");
        // R5 / R6 equality branches
        apply_check(32'h0000_1000, 32'h10A1_0003, 5, 5, "beq taken +12 R5");
        apply_check(32'h0000_1000, 32'h10A1_0003, 5, 6, "beq not taken R6");
        apply_check(32'h0000_1000, 32'h14A1_FFFF, 5, 6, "bne backward R5");
        apply_check(32'h0000_1000, 32'h14A1_FFFF, 9, 9, "bne not taken R6");
        // R7 sign tests via sub-field
        apply_check(32'h0000_2000, 32'h04A1_0002, 0, 0, "gez zero +8 R7");
        apply_check(32'h0000_2000, 32'h04A0_0002, 32'hFFFF_FFFF, 0, "ltz negative R7");
        apply_check(32'h0000_2000, 32'h04A0_0002, 0, 0, "ltz zero not taken R7");
        apply_check(32'h0000_2000, 32'h04A2_0002, 32'hFFFF_FFFF, 0, "regimm sub 2 ignored R7");
        // R8 lez/gtz incl. nonzero sub-field
        apply_check(32'h0000_3000, 32'h18A0_0004, 0, 0, "lez zero R8");
        apply_check(32'h0000_3000, 32'h1CA0_0004, 0, 0, "gtz zero not taken R8");
        apply_check(32'h0000_3000, 32'h1CA0_0004, 32'h7FFF_FFFF, 0, "gtz max R8");
        apply_check(32'h0000_3000, 32'h18A3_0004, 32'h8000_0000, 0, "lez bad sub ignored R8");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            logic [31:0] a, b;
            int sel;
            sel = $urandom % 10;
            op = (sel < 8) ? 6'(sel) : 6'($urandom);
            a = $urandom;
            case ($urandom % 4)
                0: a = 0;
                1: a = 32'h8000_0000 | a;
                default: ;
            endcase
            b = (($urandom % 3) == 0) ? a : $urandom;
            apply_check($urandom & 32'hFFFF_FFFC, rand_word(op), a, b, "random");
        end
        done = 1;
    end

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung exp finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule